// File: doc/BRIEF.md
# Ethernet Buffer Descriptor Ring Engine

This block keeps the table of buffer descriptors for a 10/100 Ethernet MAC and walks it on behalf of the frame sender and the frame receiver. One table holds both kinds of descriptor. A programmable count divides it: the entries below the count form the transmit ring, and the remaining entries form the receive ring. Each descriptor occupies two words. The first word carries length, control and status. The second word carries the buffer address. The host reads and writes the table and a small set of control registers through a simple word-wide port.

On the transmit side, the engine finds descriptors that the host has marked as owned by hardware. It offers the length, the buffer address and the CRC and pad requests to the frame sender, and holds them until the sender reports completion. It then writes the completion status back in place and returns ownership to the host. On the receive side, the engine presents the buffer of the current empty descriptor. When a frame ends, it writes back the length and error status and returns ownership. A frame that arrives with no empty descriptor is dropped. Completion events set sticky interrupt source bits, which a mask register gates onto a single interrupt line.

Top module: `eth_bd_engine`

## Requirements
- R1: Host byte offsets: 0x000 mode (bit 0 receive enable, bit 1 transmit enable), 0x004 interrupt source, 0x008 interrupt mask, 0x00C transmit count. Descriptor i has its status word at 0x400+8*i and its buffer address word at 0x404+8*i. Every location reads back what the host last wrote, unless the engine has since written it.
- R2: A write to the transmit count above NUM_BD stores NUM_BD. Entries 0 to count-1 are transmit descriptors and entries count to NUM_BD-1 are receive descriptors.
- R3: Status word layout: bit 15 owner, bit 14 interrupt request, bit 13 ring end, bit 12 pad request, bit 11 CRC request, bits [31:16] length. When transmit is enabled and the descriptor at the transmit pointer has bit 15 set, tx_req rises on the next cycle. tx_len, tx_buf, tx_crc and tx_pad are taken from that descriptor and stay stable until the cycle in which tx_done is high.
- R4: On tx_done the status word becomes {length, 0, old bits [14:9], tx_status[8:0]}. tx_status bits are: 0 carrier lost, 1 deferred, 2 late collision, 3 retry limit, [7:4] retry count, 8 underrun.
- R5: After a transmit descriptor with bit 13 set, or after entry count-1, the transmit pointer returns to entry 0. Otherwise it moves to the next entry.
- R6: With receive enabled and bit 15 set in the current receive descriptor, rx_avail is high and rx_buf shows that descriptor's address. A pulse on rx_done writes {rx_len, 0, old bits [14:9], rx_status[8:0]}, where rx_len includes the 4-byte FCS. The pointer then advances, and it returns to entry count after bit 13 or after entry NUM_BD-1.
- R7: An rx_done with receive enabled and no empty current descriptor changes no descriptor, leaves the receive pointer in place and sets source bit 4.
- R8: Source bits are: 0 transmit ok, 1 transmit error (tx_status bit 0, 2, 3 or 8), 2 receive ok, 3 receive error (rx_status bit 0, 1, 2, 3, 5 or 6), 4 dropped frame, 5 control frame sent (tx_ctrl_sent pulse), 6 control frame received (rx_status bit 8). Bits 0 to 3 and 6 are set only when the descriptor's bit 14 is set.
- R9: Writing one to a source bit clears it, and a new event in the same cycle wins over the clear. irq is high exactly when some source bit and its mask bit are both one.
- R10: Clearing transmit enable lets a frame already offered run to its write-back, and the transmit pointer then returns to entry 0. While receive is disabled, rx_done is ignored and the receive pointer sits at entry count.
- R11: After reset all registers and descriptors read zero, and tx_req, rx_avail and irq are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | ADDR_W | Host byte address |
| host_we | input | 1 | Host write strobe |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for host_addr |
| tx_req | output | 1 | Frame offered to the sender |
| tx_len | output | 16 | Offered frame length |
| tx_buf | output | 32 | Offered buffer address |
| tx_crc | output | 1 | Sender appends CRC |
| tx_pad | output | 1 | Sender pads to minimum |
| tx_done | input | 1 | Sender completion pulse |
| tx_status | input | 9 | Sender completion status |
| tx_ctrl_sent | input | 1 | Control frame sent pulse |
| rx_avail | output | 1 | An empty receive buffer is ready |
| rx_buf | output | 32 | Current receive buffer address |
| rx_done | input | 1 | Received frame end pulse |
| rx_len | input | 16 | Received length including FCS |
| rx_status | input | 9 | Received frame status |
| irq | output | 1 | Masked interrupt request |

## Verification
The assertions assume that the sender pulses tx_done only while tx_req is high. They also assume that the transmit count is not rewritten while receive is enabled, since the receive pointer's home is derived from it. The bench respects both. Its sender model answers only an offered frame, one cycle after a fixed delay. The count is reprogrammed only with both rings disabled. rx_done pulses stand alone, one cycle wide, and each is followed by idle cycles.

// File: rtl/eth_bd_pkg.sv
package eth_bd_pkg;
    localparam int OWN_BIT  = 15;
    localparam int IRQ_BIT  = 14;
    localparam int WRAP_BIT = 13;
    localparam int PAD_BIT  = 12;
    localparam int CRC_BIT  = 11;

    localparam int REG_MODE = 'h000;
    localparam int REG_SRC  = 'h004;
    localparam int REG_MASK = 'h008;
    localparam int REG_CNT  = 'h00C;

    localparam int NUM_EV = 7;

    typedef enum logic {TXW_IDLE, TXW_SEND} txw_state_e;
endpackage

// File: rtl/eth_bd_table.sv
module eth_bd_table #(
    parameter int NUM_BD = 128,
    parameter int IDX_W  = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_stat_we,
    input  logic             host_bufa_we,
    input  logic [IDX_W-1:0] host_idx,
    input  logic [31:0]      host_wdata,
    output logic [31:0]      host_stat,
    output logic [31:0]      host_bufa,
    input  logic [IDX_W-1:0] tx_idx,
    output logic [31:0]      tx_stat,
    output logic [31:0]      tx_bufa,
    input  logic             tx_wb_en,
    input  logic [31:0]      tx_wb_data,
    input  logic [IDX_W-1:0] rx_idx,
    output logic [31:0]      rx_stat,
    output logic [31:0]      rx_bufa,
    input  logic             rx_wb_en,
    input  logic [31:0]      rx_wb_data
);
    logic [31:0] stat_q [NUM_BD];
    logic [31:0] stat_d [NUM_BD];
    logic [31:0] bufa_q [NUM_BD];
    logic [31:0] bufa_d [NUM_BD];
    logic [NUM_BD-1:0] host_sel, tx_sel, rx_sel;

    for (genvar g = 0; g < NUM_BD; g++) begin : g_sel
        assign host_sel[g] = (host_idx == IDX_W'(g));
        assign tx_sel[g]   = (tx_idx == IDX_W'(g));
        assign rx_sel[g]   = (rx_idx == IDX_W'(g));
    end

    always_comb begin
        for (int i = 0; i < NUM_BD; i++) begin
            stat_d[i] = stat_q[i];
            bufa_d[i] = bufa_q[i];
            if (host_stat_we && host_sel[i]) stat_d[i] = host_wdata;
            if (host_bufa_we && host_sel[i]) bufa_d[i] = host_wdata;
            // engine write-back has priority over the host
            if (tx_wb_en && tx_sel[i]) stat_d[i] = tx_wb_data;
            if (rx_wb_en && rx_sel[i]) stat_d[i] = rx_wb_data;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_BD; i++) begin
            if (!rst_n) begin
                stat_q[i] <= '0;
                bufa_q[i] <= '0;
            end else begin
                stat_q[i] <= stat_d[i];
                bufa_q[i] <= bufa_d[i];
            end
        end
    end

    assign host_stat = stat_q[host_idx];
    assign host_bufa = bufa_q[host_idx];
    assign tx_stat   = stat_q[tx_idx];
    assign tx_bufa   = bufa_q[tx_idx];
    assign rx_stat   = stat_q[rx_idx];
    assign rx_bufa   = bufa_q[rx_idx];
endmodule

// File: rtl/eth_tx_walker.sv
module eth_tx_walker
    import eth_bd_pkg::*;
#(
    parameter int NUM_BD = 128,
    parameter int IDX_W  = 7,
    parameter int CNT_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [CNT_W-1:0] tx_count,
    input  logic [31:0]      rd_stat,
    input  logic [31:0]      rd_bufa,
    output logic [IDX_W-1:0] ptr,
    output logic             tx_req,
    output logic [15:0]      tx_len,
    output logic [31:0]      tx_buf,
    output logic             tx_crc,
    output logic             tx_pad,
    input  logic             tx_done,
    input  logic [8:0]       tx_status,
    output logic             wb_en,
    output logic [31:0]      wb_data,
    output logic             ev_ok,
    output logic             ev_err
);
    typedef struct packed {
        txw_state_e       state;
        logic [IDX_W-1:0] ptr;
        logic [31:0]      cur;
        logic [31:0]      bufa;
    } txw_regs_t;

    txw_regs_t r_q, r_d;
    logic      at_end, bad;

    always_comb begin
        r_d     = r_q;
        wb_en   = 1'b0;
        wb_data = {r_q.cur[31:16], 1'b0, r_q.cur[14:9], tx_status};
        ev_ok   = 1'b0;
        ev_err  = 1'b0;
        at_end  = r_q.cur[WRAP_BIT] || ((CNT_W'(r_q.ptr) + CNT_W'(1)) == tx_count);
        bad     = tx_status[0] | tx_status[2] | tx_status[3] | tx_status[8];
        case (r_q.state)
            TXW_IDLE: begin
                if (!enable) begin
                    r_d.ptr = '0;
                end else if (tx_count != '0 && rd_stat[OWN_BIT]) begin
                    r_d.state = TXW_SEND;
                    r_d.cur   = rd_stat;
                    r_d.bufa  = rd_bufa;
                end
            end
            default: begin
                if (tx_done) begin
                    wb_en     = 1'b1;
                    ev_err    = r_q.cur[IRQ_BIT] && bad;
                    ev_ok     = r_q.cur[IRQ_BIT] && !bad;
                    r_d.state = TXW_IDLE;
                    r_d.ptr   = (at_end || !enable) ? '0 : r_q.ptr + IDX_W'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{state: TXW_IDLE, ptr: '0, cur: '0, bufa: '0};
        else        r_q <= r_d;
    end

    assign ptr    = r_q.ptr;
    assign tx_req = (r_q.state == TXW_SEND);
    assign tx_len = r_q.cur[31:16];
    assign tx_buf = r_q.bufa;
    assign tx_crc = r_q.cur[CRC_BIT];
    assign tx_pad = r_q.cur[PAD_BIT];

    logic unused_cur;
    assign unused_cur = ^{r_q.cur[15], r_q.cur[8:0]};

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req && !tx_done |=> tx_req && $stable(tx_len) && $stable(tx_buf)); // R3
    AST_TX_PTR_HOME: assert property (@(posedge clk) disable iff (!rst_n)
        !enable && !tx_req |=> ptr == '0); // R10
endmodule

// File: rtl/eth_rx_walker.sv
module eth_rx_walker
    import eth_bd_pkg::*;
#(
    parameter int NUM_BD = 128,
    parameter int IDX_W  = 7,
    parameter int CNT_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [CNT_W-1:0] tx_count,
    input  logic [31:0]      rd_stat,
    input  logic [31:0]      rd_bufa,
    output logic [IDX_W-1:0] ptr,
    output logic             rx_avail,
    output logic [31:0]      rx_buf,
    input  logic             rx_done,
    input  logic [15:0]      rx_len,
    input  logic [8:0]       rx_status,
    output logic             wb_en,
    output logic [31:0]      wb_data,
    output logic             ev_ok,
    output logic             ev_err,
    output logic             ev_ctrl,
    output logic             ev_drop
);
    typedef struct packed {
        logic [IDX_W-1:0] ptr;
    } rxw_regs_t;

    rxw_regs_t        r_q, r_d;
    logic             region_ok, bad, at_end;
    logic [IDX_W-1:0] first;

    assign region_ok = (tx_count < CNT_W'(NUM_BD));
    assign first     = tx_count[IDX_W-1:0];
    assign rx_avail  = enable && region_ok && rd_stat[OWN_BIT];
    assign rx_buf    = rd_bufa;

    always_comb begin
        r_d     = r_q;
        wb_en   = 1'b0;
        wb_data = {rx_len, 1'b0, rd_stat[14:9], rx_status};
        ev_ok   = 1'b0;
        ev_err  = 1'b0;
        ev_ctrl = 1'b0;
        ev_drop = 1'b0;
        bad     = rx_status[0] | rx_status[1] | rx_status[2] | rx_status[3]
                | rx_status[5] | rx_status[6];
        at_end  = rd_stat[WRAP_BIT] || (r_q.ptr == IDX_W'(NUM_BD - 1));
        if (!enable || !region_ok) begin
            r_d.ptr = first;
            if (enable && rx_done) ev_drop = 1'b1;
        end else if (rx_done) begin
            if (rd_stat[OWN_BIT]) begin
                wb_en   = 1'b1;
                ev_ok   = rd_stat[IRQ_BIT] && !bad;
                ev_err  = rd_stat[IRQ_BIT] && bad;
                ev_ctrl = rd_stat[IRQ_BIT] && rx_status[8];
                r_d.ptr = at_end ? first : r_q.ptr + IDX_W'(1);
            end else begin
                ev_drop = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ptr = r_q.ptr;

    logic unused_stat;
    assign unused_stat = ^{rd_stat[31:16], rd_stat[8:0]};

    AST_RX_DROP_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done && enable && !rx_avail |=> $stable(ptr)); // R7
    AST_RX_PTR_HOME: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> ptr == $past(tx_count[IDX_W-1:0])); // R10
endmodule

// File: rtl/eth_bd_engine.sv
module eth_bd_engine
    import eth_bd_pkg::*;
#(
    parameter int NUM_BD = 128,
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_we,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    output logic              tx_req,
    output logic [15:0]       tx_len,
    output logic [31:0]       tx_buf,
    output logic              tx_crc,
    output logic              tx_pad,
    input  logic              tx_done,
    input  logic [8:0]        tx_status,
    input  logic              tx_ctrl_sent,
    output logic              rx_avail,
    output logic [31:0]       rx_buf,
    input  logic              rx_done,
    input  logic [15:0]       rx_len,
    input  logic [8:0]        rx_status,
    output logic              irq
);
    localparam int IDX_W = (NUM_BD > 1) ? $clog2(NUM_BD) : 1;
    localparam int CNT_W = $clog2(NUM_BD + 1);

    typedef struct packed {
        logic [1:0]        mode;
        logic [NUM_EV-1:0] mask;
        logic [NUM_EV-1:0] src;
        logic [CNT_W-1:0]  cnt;
    } eng_regs_t;

    eng_regs_t r_q, r_d;

    logic              is_desc;
    logic [IDX_W-1:0]  host_idx, tx_ptr, rx_ptr;
    logic [31:0]       host_stat, host_bufa, tx_stat, tx_bufa, rx_stat, rx_bufa;
    logic              tx_wb_en, rx_wb_en;
    logic [31:0]       tx_wb_data, rx_wb_data;
    logic              tx_ok, tx_err, rx_ok, rx_err, rx_ctrl, rx_drop;
    logic [NUM_EV-1:0] ev_vec, clr;

    assign is_desc  = host_addr[ADDR_W-1];
    assign host_idx = host_addr[IDX_W+2:3];

    eth_bd_table #(.NUM_BD(NUM_BD), .IDX_W(IDX_W)) u_table (
        .clk, .rst_n,
        .host_stat_we (host_we && is_desc && !host_addr[2]),
        .host_bufa_we (host_we && is_desc && host_addr[2]),
        .host_idx, .host_wdata, .host_stat, .host_bufa,
        .tx_idx (tx_ptr), .tx_stat, .tx_bufa,
        .tx_wb_en, .tx_wb_data,
        .rx_idx (rx_ptr), .rx_stat, .rx_bufa,
        .rx_wb_en, .rx_wb_data
    );

    eth_tx_walker #(.NUM_BD(NUM_BD), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_tx (
        .clk, .rst_n,
        .enable (r_q.mode[1]), .tx_count (r_q.cnt),
        .rd_stat (tx_stat), .rd_bufa (tx_bufa), .ptr (tx_ptr),
        .tx_req, .tx_len, .tx_buf, .tx_crc, .tx_pad, .tx_done, .tx_status,
        .wb_en (tx_wb_en), .wb_data (tx_wb_data),
        .ev_ok (tx_ok), .ev_err (tx_err)
    );

    eth_rx_walker #(.NUM_BD(NUM_BD), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_rx (
        .clk, .rst_n,
        .enable (r_q.mode[0]), .tx_count (r_q.cnt),
        .rd_stat (rx_stat), .rd_bufa (rx_bufa), .ptr (rx_ptr),
        .rx_avail, .rx_buf, .rx_done, .rx_len, .rx_status,
        .wb_en (rx_wb_en), .wb_data (rx_wb_data),
        .ev_ok (rx_ok), .ev_err (rx_err), .ev_ctrl (rx_ctrl), .ev_drop (rx_drop)
    );

    assign ev_vec = {rx_ctrl, tx_ctrl_sent, rx_drop, rx_err, rx_ok, tx_err, tx_ok};

    always_comb begin
        r_d = r_q;
        clr = '0;
        if (host_we && !is_desc) begin
            if (host_addr == ADDR_W'(REG_MODE)) r_d.mode = host_wdata[1:0];
            if (host_addr == ADDR_W'(REG_MASK)) r_d.mask = host_wdata[NUM_EV-1:0];
            if (host_addr == ADDR_W'(REG_SRC))  clr      = host_wdata[NUM_EV-1:0];
            if (host_addr == ADDR_W'(REG_CNT))
                r_d.cnt = (host_wdata > 32'(NUM_BD)) ? CNT_W'(NUM_BD)
                                                     : host_wdata[CNT_W-1:0];
        end
        r_d.src = (r_q.src & ~clr) | ev_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        host_rdata = '0;
        if (is_desc)                             host_rdata = host_addr[2] ? host_bufa : host_stat;
        else if (host_addr == ADDR_W'(REG_MODE)) host_rdata = 32'(r_q.mode);
        else if (host_addr == ADDR_W'(REG_SRC))  host_rdata = 32'(r_q.src);
        else if (host_addr == ADDR_W'(REG_MASK)) host_rdata = 32'(r_q.mask);
        else if (host_addr == ADDR_W'(REG_CNT))  host_rdata = 32'(r_q.cnt);
    end

    assign irq = |(r_q.src & r_q.mask);

    AST_SRC_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        host_we && host_addr == ADDR_W'(REG_SRC) && ev_vec == '0
        |=> (r_q.src & $past(host_wdata[NUM_EV-1:0])) == '0); // R9
    AST_DROP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done && r_q.mode[0] && !rx_avail |=> r_q.src[4]); // R7
    AST_CNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt <= CNT_W'(NUM_BD)); // R2
endmodule

// File: tb/tb_eth_bd_engine.sv
module tb_eth_bd_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] host_addr = '0;
    logic        host_we = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        tx_req, tx_crc, tx_pad, rx_avail, irq;
    logic [15:0] tx_len;
    logic [31:0] tx_buf, rx_buf;
    logic        tx_done = 1'b0, tx_ctrl_sent = 1'b0, rx_done = 1'b0;
    logic [8:0]  tx_status = '0, rx_status = '0;
    logic [15:0] rx_len = '0;

    int checks = 0;
    int errors = 0;

    typedef struct packed {
        logic [15:0] len;
        logic [31:0] bufa;
        logic        crc;
        logic        pad;
        logic [8:0]  st;
    } txexp_t;
    txexp_t exq[$];

    eth_bd_engine dut (
        .clk, .rst_n, .host_addr, .host_we, .host_wdata, .host_rdata,
        .tx_req, .tx_len, .tx_buf, .tx_crc, .tx_pad, .tx_done, .tx_status,
        .tx_ctrl_sent, .rx_avail, .rx_buf, .rx_done, .rx_len, .rx_status, .irq
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic wr(input logic [10:0] a, input logic [31:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rd(input logic [10:0] a, output logic [31:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic chk_rd(input string req, input logic [10:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    function automatic logic [10:0] ds(input int i);
        return 11'(32'h400 + 8 * i);
    endfunction

    task automatic arm(input int i, input logic [31:0] st, input logic [31:0] ba);
        wr(ds(i) + 11'd4, ba);
        wr(ds(i), st);
    endtask

    task automatic pulse_rx(input logic [15:0] len, input logic [8:0] st);
        @(negedge clk);
        rx_len = len; rx_status = st; rx_done = 1'b1;
        @(negedge clk);
        rx_done = 1'b0;
    endtask

    task automatic wait_tx();
        int n = 0;
        while ((exq.size() != 0 || tx_req || tx_done) && n < 2000) begin
            @(negedge clk);
            n++;
        end
        repeat (2) @(negedge clk);
    endtask

    // scoreboard monitor: models the frame sender and compares each offer
    initial begin
        txexp_t e;
        forever begin
            @(negedge clk);
            if (tx_req) begin
                if (exq.size() == 0) begin
                    chk("R3 unexpected offer", {tx_len, 16'h0}, 32'h0);
                    e = '0;
                end else begin
                    e = exq.pop_front();
                    chk("R3 tx_len", 32'(tx_len), 32'(e.len));
                    chk("R3 tx_buf", tx_buf, e.bufa);
                    chk("R3 tx_crc/pad", {30'h0, tx_crc, tx_pad}, {30'h0, e.crc, e.pad});
                end
                repeat (5) @(negedge clk);
                tx_status = e.st; tx_done = 1'b1;
                @(negedge clk);
                tx_done = 1'b0;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        chk_rd("R11 mode", 11'h000, 0);
        chk_rd("R11 src", 11'h004, 0);
        chk_rd("R11 mask", 11'h008, 0);
        chk_rd("R11 count", 11'h00C, 0);
        chk_rd("R11 desc", ds(5), 0);
        chk("R11 outputs", {29'h0, tx_req, rx_avail, irq}, 0);

        // R2 count cap
        wr(11'h00C, 300);
        chk_rd("R2 cap", 11'h00C, 128);
        wr(11'h00C, 4);
        chk_rd("R2 count", 11'h00C, 4);

        // R1 host access
        arm(0, 32'h003C_D800, 32'hA000_0000);
        arm(1, 32'h0064_C800, 32'hA000_0800);
        chk_rd("R1 addr word", ds(1) + 11'd4, 32'hA000_0800);
        chk_rd("R1 stat word", ds(1), 32'h0064_C800);

        // R3 R4 transmit two frames
        wr(11'h008, 32'h7F);
        exq.push_back('{16'd60, 32'hA000_0000, 1'b1, 1'b1, 9'h002});
        exq.push_back('{16'd100, 32'hA000_0800, 1'b1, 1'b0, 9'h100});
        wr(11'h000, 32'h2);
        wait_tx();
        chk_rd("R4 wb0", ds(0), 32'h003C_5802);
        chk_rd("R4 wb1", ds(1), 32'h0064_4900);
        chk_rd("R8 tx ok+err", 11'h004, 32'h03);
        chk("R9 irq high", 32'(irq), 1);
        wr(11'h004, 32'h01);
        chk_rd("R9 w1c one", 11'h004, 32'h02);
        wr(11'h004, 32'h02);
        chk_rd("R9 w1c two", 11'h004, 32'h00);

        // R5 wrap bit; R8 no interrupt request
        exq.push_back('{16'd32, 32'hA000_1000, 1'b1, 1'b0, 9'h000});
        arm(2, 32'h0020_A800, 32'hA000_1000);
        wait_tx();
        chk_rd("R8 no irq bit", 11'h004, 32'h00);
        chk_rd("R4 wb2", ds(2), 32'h0020_2800);
        exq.push_back('{16'd64, 32'hA000_2000, 1'b1, 1'b0, 9'h008});
        arm(0, 32'h0040_C800, 32'hA000_2000);
        wait_tx();
        chk_rd("R5 wrap to 0", ds(0), 32'h0040_4808);
        chk_rd("R8 retry limit err", 11'h004, 32'h02);
        wr(11'h004, 32'h7F);

        // R5 wrap after entry count-1
        for (int i = 1; i < 5; i++) begin
            exq.push_back('{16'(15 + i), 32'hB000_0000 + 32'(i), 1'b0, 1'b0, 9'h000});
            arm(i % 4, {16'(15 + i), 16'h8000}, 32'hB000_0000 + 32'(i));
        end
        wait_tx();
        chk("R5 ring end", 32'(exq.size()), 0);
        chk_rd("R5 entry0 sent", ds(0), 32'h0013_0000);

        // R6 receive
        arm(4, 32'h0000_C000, 32'h0000_1000);
        arm(5, 32'h0000_E000, 32'h0000_2000);
        wr(11'h000, 32'h3);
        chk("R6 avail", 32'(rx_avail), 1);
        chk("R6 buf4", rx_buf, 32'h1000);
        pulse_rx(16'd68, 9'h000);
        chk_rd("R6 wb4", ds(4), 32'h0044_4000);
        chk_rd("R8 rx ok", 11'h004, 32'h04);
        chk("R6 buf5", rx_buf, 32'h2000);
        pulse_rx(16'd1522, 9'h002);
        chk_rd("R6 wb5", ds(5), 32'h05F2_6002);
        chk_rd("R8 rx err", 11'h004, 32'h0C);
        chk("R6 wrap avail", 32'(rx_avail), 0);
        chk("R6 wrap buf", rx_buf, 32'h1000);
        wr(11'h004, 32'h7F);

        // R7 drop
        pulse_rx(16'd40, 9'h000);
        chk_rd("R7 busy", 11'h004, 32'h10);
        chk_rd("R7 desc kept", ds(4), 32'h0044_4000);
        wr(11'h004, 32'h7F);
        arm(4, 32'h0000_C000, 32'h0000_1000);
        pulse_rx(16'd64, 9'h100);
        chk_rd("R7 ptr kept", ds(4), 32'h0040_4100);
        chk_rd("R8 rx ctrl", 11'h004, 32'h44);
        wr(11'h004, 32'h7F);

        // R8 control sent; R9 mask
        @(negedge clk); tx_ctrl_sent = 1'b1;
        @(negedge clk); tx_ctrl_sent = 1'b0;
        chk_rd("R8 ctrl sent", 11'h004, 32'h20);
        wr(11'h008, 32'h00);
        chk("R9 masked", 32'(irq), 0);
        wr(11'h008, 32'h20);
        chk("R9 unmasked", 32'(irq), 1);
        wr(11'h004, 32'h7F);
        chk("R9 cleared", 32'(irq), 0);

        // R10 transmit disable mid-frame
        exq.push_back('{16'd80, 32'hC000_0000, 1'b0, 1'b0, 9'h000});
        arm(1, 32'h0050_C000, 32'hC000_0000);
        for (int n = 0; n < 50 && !tx_req; n++) @(negedge clk);
        wr(11'h000, 32'h1);
        wait_tx();
        chk_rd("R10 frame finished", ds(1), 32'h0050_4000);
        chk_rd("R10 event", 11'h004, 32'h01);
        arm(2, 32'h0011_8000, 32'hC000_1000);
        arm(0, 32'h0022_8000, 32'hD000_0000);
        repeat (10) @(negedge clk);
        chk("R10 idle while off", 32'(tx_req), 0);
        exq.push_back('{16'h22, 32'hD000_0000, 1'b0, 1'b0, 9'h000});
        wr(11'h000, 32'h3);
        wait_tx();
        chk_rd("R10 restart at 0", ds(2), 32'h0011_8000);

        // R10 receive disable
        wr(11'h004, 32'h7F);
        wr(11'h000, 32'h0);
        chk("R10 rx off avail", 32'(rx_avail), 0);
        pulse_rx(16'd50, 9'h000);
        chk_rd("R10 rx ignored", 11'h004, 32'h00);
        arm(4, 32'h0000_C000, 32'h0000_1000);
        wr(11'h000, 32'h1);
        chk("R10 rx home", rx_buf, 32'h1000);
        rd(11'h000, v);
        chk("R1 mode readback", v, 32'h1);

        summary();
    end
endmodule